// File: doc/BRIEF.md
# Power-down and wake-up controller

This block manages the lowest-power state of a small microcontroller core. Software asks for the state by writing 1 to the power-down bit of the power control register. Once that write lands, the core and peripheral clock gates close at once and the oscillator enable drops one cycle later. The write that sets the bit is therefore the last instruction the core executes.

Two events end the state. The first is an external interrupt pin that is low, enabled and configured as level-sensitive. The pin drives the oscillator enable directly, without a clock, so the oscillator can start. A synchronised copy of the pin then moves the controller through a stabilisation count into a hold phase. In the hold phase only the peripheral clock runs. The core clock returns, with a one-cycle resume pulse, once the pin has been released.

The second event is a high level on the asynchronous reset pin. It clears the power-down bit without a clock and forces the oscillator on. After the same stabilisation count, the core runs for a short fixed burst with internal RAM access blocked. A one-cycle reset request then hands control to the core's reset sequence.

Top module: `pwrdn_ctl`

## Requirements
- R1: After the synchronous reset `rst`, `osc_en`, `cpu_clk_en` and `per_clk_en` are 1, and `core_resume`, `core_rst_req` and `ram_block` are 0.
- R2: A write (`pwr_wr`=1) with `pwr_pd`=1 while running drops `cpu_clk_en` and `per_clk_en` in the cycle after the write edge. `osc_en` drops one cycle later. Whenever `osc_en` is 0, both clock enables are 0.
- R3: A write with `pwr_pd`=0 leaves both clock enables at 1.
- R4: In power-down, a low level on either `irq_n` pin whose `irq_en` bit is 1 and whose `irq_lvl` bit is 1 (level mode) raises `osc_en` in the same cycle, before any clock edge.
- R5: In power-down, a low pin whose `irq_lvl` bit is 0 (edge mode), or whose `irq_en` bit is 0, leaves `osc_en` and both clock enables at 0.
- R6: After a qualifying pin goes low, `per_clk_en` stays 0 for exactly STAB_CYCLES + 2 cycles. Two cycles are synchroniser delay and STAB_CYCLES are oscillator stabilisation.
- R7: After an interrupt wake, while the pin stays low, `per_clk_en` is 1 and `cpu_clk_en` is 0.
- R8: When the pin is released, `cpu_clk_en` rises after two further cycles at 0. `core_resume` is 1 in that first cycle only.
- R9: Raising `rst_pin` in power-down sets `osc_en` to 1 at once. Both clocks then return together after STAB_CYCLES + 2 cycles.
- R10: After a reset wake, `ram_block` is 1 for exactly BURST_CYCLES cycles with `cpu_clk_en` at 1. `core_rst_req` is 1 for one cycle as `ram_block` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high block reset |
| pwr_wr | input | 1 | Write strobe for the power control register |
| pwr_pd | input | 1 | Power-down bit value written |
| irq_n | input | N_IRQ | Active-low external interrupt pins |
| irq_en | input | N_IRQ | Per-pin interrupt enable |
| irq_lvl | input | N_IRQ | Per-pin mode, 1 = level-sensitive, 0 = edge |
| rst_pin | input | 1 | Asynchronous active-high reset pin |
| osc_en | output | 1 | Oscillator enable |
| cpu_clk_en | output | 1 | Core clock gate enable |
| per_clk_en | output | 1 | Peripheral clock gate enable |
| core_resume | output | 1 | One-cycle pulse when the core resumes after an interrupt wake |
| core_rst_req | output | 1 | One-cycle reset request after the reset-wake burst |
| ram_block | output | 1 | Internal RAM access blocked during the reset-wake burst |

## Verification
The hardest state to reach is the hold phase after an interrupt wake. There the peripheral clock runs but the core clock must not, which needs a pin held low through the whole stabilisation count. The stimulus enters power-down and keeps a level-mode pin low until the peripheral enable rises, then holds it for several more cycles before releasing it. The reset burst is reached the same way, by raising the reset pin in power-down and counting the cycles during which RAM is blocked. Edge-mode and disabled pins are held low for long windows to show that no wake occurs.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;

    // Controller phases
    typedef enum logic [1:0] {
        PS_ACTIVE   = 2'd0,
        PS_DOWN     = 2'd1,
        PS_RESTART  = 2'd2,
        PS_WAIT_REL = 2'd3
    } pstate_e;

    // Gate bundle driven to the clock tree
    typedef struct packed {
        logic osc;
        logic per;
        logic cpu;
    } gate_t;

    // A pin may wake the part only when low, enabled and level-configured
    function automatic logic irq_qualifies(input logic pin_n, input logic en, input logic lvl);
        return (!pin_n) && en && lvl;
    endfunction

    // Counter width able to hold LIMIT-1
    function automatic int unsigned cnt_width(input int unsigned lim);
        return (lim < 2) ? 1 : $clog2(lim);
    endfunction

endpackage

// File: rtl/pwrdn_sync.sv
module pwrdn_sync #(
    parameter int unsigned W       = 1,
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) begin
                stg[s] <= {W{RST_VAL}};
            end
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/pwrdn_wake_qual.sv
module pwrdn_wake_qual
    import pwrdn_pkg::*;
#(
    parameter int unsigned N_IRQ  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_IRQ-1:0] irq_n,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic [N_IRQ-1:0] irq_lvl,
    output logic             wake_raw,
    output logic             wake_sync
);

    logic [N_IRQ-1:0] irq_n_s;
    logic [N_IRQ-1:0] hit_raw;
    logic [N_IRQ-1:0] hit_sync;

    // Pins idle high, so the synchroniser resets to 1
    pwrdn_sync #(
        .W      (N_IRQ),
        .STAGES (STAGES),
        .RST_VAL(1'b1)
    ) u_isync (
        .clk(clk),
        .rst(rst),
        .d  (irq_n),
        .q  (irq_n_s)
    );

    for (genvar i = 0; i < N_IRQ; i++) begin : g_pin
        // Unclocked path: lets the oscillator start while clocks are stopped
        assign hit_raw[i]  = irq_qualifies(irq_n[i], irq_en[i], irq_lvl[i]);
        // Clocked path: used for every state decision, including release
        assign hit_sync[i] = irq_qualifies(irq_n_s[i], irq_en[i], irq_lvl[i]);
    end

    assign wake_raw  = |hit_raw;
    assign wake_sync = |hit_sync;

endmodule

// File: rtl/pwrdn_count.sv
module pwrdn_count
    import pwrdn_pkg::*;
#(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    output logic done
);

    localparam int unsigned CW   = cnt_width(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    assign done = en && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (en && !done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/pwrdn_ctl.sv
module pwrdn_ctl
    import pwrdn_pkg::*;
#(
    parameter int unsigned N_IRQ        = 2,
    parameter int unsigned STAB_CYCLES  = 1024,
    parameter int unsigned BURST_CYCLES = 4,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwr_wr,
    input  logic             pwr_pd,
    input  logic [N_IRQ-1:0] irq_n,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic [N_IRQ-1:0] irq_lvl,
    input  logic             rst_pin,
    output logic             osc_en,
    output logic             cpu_clk_en,
    output logic             per_clk_en,
    output logic             core_resume,
    output logic             core_rst_req,
    output logic             ram_block
);

    pstate_e state_q, state_d;
    logic    pd_q;
    logic    rflag_q, rflag_d;
    logic    resume_q, rreq_q;
    logic    wake_raw, wake_sync;
    logic    rpin_s, rpin_d, rpin_rise;
    logic    pd_set, irq_exit;
    logic    stab_done, burst_done, burst_active;
    gate_t   gate;

    // Reset pin: asynchronous effects below, synchronised copy for the FSM
    pwrdn_sync #(
        .W      (1),
        .STAGES (SYNC_STAGES),
        .RST_VAL(1'b0)
    ) u_rsync (
        .clk(clk),
        .rst(rst),
        .d  (rst_pin),
        .q  (rpin_s)
    );

    always_ff @(posedge clk) begin
        if (rst) rpin_d <= 1'b0;
        else     rpin_d <= rpin_s;
    end

    assign rpin_rise = rpin_s && !rpin_d;

    pwrdn_wake_qual #(
        .N_IRQ (N_IRQ),
        .STAGES(SYNC_STAGES)
    ) u_wake (
        .clk      (clk),
        .rst      (rst),
        .irq_n    (irq_n),
        .irq_en   (irq_en),
        .irq_lvl  (irq_lvl),
        .wake_raw (wake_raw),
        .wake_sync(wake_sync)
    );

    // Oscillator stabilisation count
    pwrdn_count #(.LIMIT(STAB_CYCLES)) u_stab (
        .clk (clk),
        .rst (rst),
        .clr (state_q != PS_RESTART),
        .en  (state_q == PS_RESTART),
        .done(stab_done)
    );

    // Short execution burst after a reset wake
    assign burst_active = (state_q == PS_ACTIVE) && rflag_q;

    pwrdn_count #(.LIMIT(BURST_CYCLES)) u_burst (
        .clk (clk),
        .rst (rst),
        .clr (!burst_active),
        .en  (burst_active),
        .done(burst_done)
    );

    // Power-down bit: set by software, cleared by an interrupt wake,
    // cleared without a clock by the reset pin
    assign pd_set = pwr_wr && pwr_pd && (state_q == PS_ACTIVE) && !rflag_q && !pd_q;

    always_ff @(posedge clk or posedge rst_pin) begin
        if (rst_pin) begin
            pd_q <= 1'b0;
        end else if (rst) begin
            pd_q <= 1'b0;
        end else if (pd_set) begin
            pd_q <= 1'b1;
        end else if (irq_exit) begin
            pd_q <= 1'b0;
        end
    end

    always_comb begin
        state_d  = state_q;
        rflag_d  = rflag_q;
        irq_exit = 1'b0;
        if (rpin_rise) begin
            state_d = PS_RESTART;
            rflag_d = 1'b1;
        end else begin
            unique case (state_q)
                PS_ACTIVE: begin
                    if (burst_done) rflag_d = 1'b0;
                    if (pd_q)       state_d = PS_DOWN;
                end
                PS_DOWN: begin
                    if (wake_sync) begin
                        state_d  = PS_RESTART;
                        rflag_d  = 1'b0;
                        irq_exit = 1'b1;
                    end
                end
                PS_RESTART: begin
                    if (stab_done) state_d = rflag_q ? PS_ACTIVE : PS_WAIT_REL;
                end
                PS_WAIT_REL: begin
                    if (!wake_sync) state_d = PS_ACTIVE;
                end
                default: state_d = PS_ACTIVE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= PS_ACTIVE;
            rflag_q  <= 1'b0;
            resume_q <= 1'b0;
            rreq_q   <= 1'b0;
        end else begin
            state_q  <= state_d;
            rflag_q  <= rflag_d;
            resume_q <= (state_q == PS_WAIT_REL) && (state_d == PS_ACTIVE);
            rreq_q   <= burst_done && !rpin_rise;
        end
    end

    always_comb begin
        gate.cpu = (state_q == PS_ACTIVE) && !pd_q;
        gate.per = gate.cpu || (state_q == PS_WAIT_REL);
        gate.osc = (state_q != PS_DOWN) || wake_raw || rst_pin;
    end

    assign osc_en       = gate.osc;
    assign cpu_clk_en   = gate.cpu;
    assign per_clk_en   = gate.per;
    assign core_resume  = resume_q;
    assign core_rst_req = rreq_q;
    assign ram_block    = burst_active;

endmodule

// File: rtl/pwrdn_ctl_chk.sv
module pwrdn_ctl_chk (
    input logic clk,
    input logic rst,
    input logic rst_pin,
    input logic pwr_wr,
    input logic pwr_pd,
    input logic rpin_rise,
    input logic osc_en,
    input logic cpu_clk_en,
    input logic per_clk_en,
    input logic core_resume,
    input logic core_rst_req,
    input logic ram_block
);

    assert_dark_osc_R2: assert property (@(posedge clk) disable iff (rst)
        !osc_en |-> (!cpu_clk_en && !per_clk_en));

    assert_keep_run_R3: assert property (@(posedge clk) disable iff (rst)
        (pwr_wr && !pwr_pd && cpu_clk_en && !rpin_rise) |=> cpu_clk_en);

    assert_cpu_needs_per_R7: assert property (@(posedge clk) disable iff (rst)
        cpu_clk_en |-> per_clk_en);

    assert_resume_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        core_resume |=> !core_resume);

    assert_resume_runs_R8: assert property (@(posedge clk) disable iff (rst)
        core_resume |-> (cpu_clk_en && !ram_block));

    assert_rstpin_osc_R9: assert property (@(posedge clk) disable iff (rst)
        rst_pin |-> osc_en);

    assert_rreq_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        core_rst_req |=> !core_rst_req);

    assert_burst_runs_R10: assert property (@(posedge clk) disable iff (rst)
        ram_block |-> cpu_clk_en);

endmodule

bind pwrdn_ctl pwrdn_ctl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .rst_pin     (rst_pin),
    .pwr_wr      (pwr_wr),
    .pwr_pd      (pwr_pd),
    .rpin_rise   (rpin_rise),
    .osc_en      (osc_en),
    .cpu_clk_en  (cpu_clk_en),
    .per_clk_en  (per_clk_en),
    .core_resume (core_resume),
    .core_rst_req(core_rst_req),
    .ram_block   (ram_block)
);

// File: tb/sim_pwrdn_ctl.sv
`timescale 1ns/1ps
module sim_pwrdn_ctl;

    localparam int STAB  = 16;
    localparam int BURST = 4;
    localparam int NI    = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pwr_wr = 1'b0;
    logic          pwr_pd = 1'b0;
    logic [NI-1:0] irq_n = '1;
    logic [NI-1:0] irq_en = '0;
    logic [NI-1:0] irq_lvl = '0;
    logic          rst_pin = 1'b0;
    logic          osc_en, cpu_clk_en, per_clk_en, core_resume, core_rst_req, ram_block;

    always #10 clk = ~clk;   // 50 MHz

    pwrdn_ctl #(
        .N_IRQ       (NI),
        .STAB_CYCLES (STAB),
        .BURST_CYCLES(BURST),
        .SYNC_STAGES (2)
    ) u0 (
        .clk         (clk),
        .rst         (rst),
        .pwr_wr      (pwr_wr),
        .pwr_pd      (pwr_pd),
        .irq_n       (irq_n),
        .irq_en      (irq_en),
        .irq_lvl     (irq_lvl),
        .rst_pin     (rst_pin),
        .osc_en      (osc_en),
        .cpu_clk_en  (cpu_clk_en),
        .per_clk_en  (per_clk_en),
        .core_resume (core_resume),
        .core_rst_req(core_rst_req),
        .ram_block   (ram_block)
    );

    typedef struct {
        string req;
        int    val;
    } exp_t;

    exp_t exp_q[$];
    int   act_q[$];
    int   checks = 0;
    int   errors = 0;
    int   cyc    = 0;
    bit   ended  = 1'b0;

    // Driver side: expected value and observation go to the scoreboard
    task automatic check(input string req, input int exp, input int act);
        exp_t e;
        e.req = req;
        e.val = exp;
        exp_q.push_back(e);
        act_q.push_back(act);
    endtask

    // Monitor side: pops and compares
    initial begin
        forever begin
            #1;
            while (exp_q.size() > 0 && act_q.size() > 0) begin
                exp_t e;
                int   a;
                e = exp_q.pop_front();
                a = act_q.pop_front();
                checks++;
                if (a != e.val) begin
                    errors++;
                    $display("FAIL %s actual %0d expected %0d", e.req, a, e.val);
                end
            end
        end
    end

    task automatic finish_run();
        ended = 1'b1;
        #3;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !ended) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected below 20000", cyc);
            finish_run();
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic write_pd(input logic v);
        pwr_pd = v;
        pwr_wr = 1'b1;
        tick();
        pwr_wr = 1'b0;
        pwr_pd = 1'b0;
    endtask

    task automatic wait_per(output int n);
        n = 0;
        for (int k = 0; k < 1000; k++) begin
            tick();
            if (per_clk_en) break;
            n++;
        end
    endtask

    task automatic wait_cpu(output int n);
        n = 0;
        for (int k = 0; k < 1000; k++) begin
            tick();
            if (cpu_clk_en) break;
            n++;
        end
    endtask

    initial begin
        int n, c, p, o, b;

        // R1 reset state
        repeat (3) tick();
        rst = 1'b0;
        tick();
        check("R1 reset outputs", 6'b111000,
              int'({osc_en, cpu_clk_en, per_clk_en, core_resume, core_rst_req, ram_block}));

        // R3 write with power-down bit clear
        write_pd(1'b0);
        c = cpu_clk_en;
        for (int i = 0; i < 4; i++) begin tick(); c += cpu_clk_en; end
        check("R3 cpu stays on", 5, c);

        // R2 power-down entry
        write_pd(1'b1);
        check("R2 gates off osc on", 3'b001, int'({cpu_clk_en, per_clk_en, osc_en}));
        tick();
        check("R2 osc off", 3'b000, int'({cpu_clk_en, per_clk_en, osc_en}));

        // R5 edge-mode pin low
        irq_en = 2'b11; irq_lvl = 2'b00; irq_n = 2'b10;
        o = 0;
        for (int i = 0; i < 30; i++) begin tick(); o += osc_en + cpu_clk_en + per_clk_en; end
        check("R5 edge mode no wake", 0, o);
        irq_n = 2'b11;
        repeat (3) tick();

        // R5 disabled pin low
        irq_en = 2'b00; irq_lvl = 2'b11; irq_n = 2'b01;
        o = 0;
        for (int i = 0; i < 30; i++) begin tick(); o += osc_en + cpu_clk_en + per_clk_en; end
        check("R5 disabled no wake", 0, o);
        irq_n = 2'b11;
        repeat (3) tick();

        // R4 wake on pin 0
        irq_en = 2'b11; irq_lvl = 2'b11;
        tick();
        irq_n = 2'b10;
        #2;
        check("R4 osc on at once pin0", 1, int'(osc_en));

        // R6 restart length
        wait_per(n);
        check("R6 per off cycles", STAB + 2, n);

        // R7 hold phase
        c = 0; p = 0;
        for (int i = 0; i < 5; i++) begin tick(); c += cpu_clk_en; p += per_clk_en; end
        check("R7 cpu held off", 0, c);
        check("R7 per running", 5, p);

        // R8 release
        irq_n = 2'b11;
        wait_cpu(n);
        check("R8 release delay", 2, n);
        check("R8 resume pulse", 1, int'(core_resume));
        tick();
        check("R8 resume one cycle", 2'b10, int'({cpu_clk_en, core_resume}));

        // R4 wake on pin 1, with R6 and R8 repeated
        write_pd(1'b1);
        tick();
        irq_en = 2'b10; irq_lvl = 2'b10; irq_n = 2'b01;
        #2;
        check("R4 osc on at once pin1", 1, int'(osc_en));
        wait_per(n);
        check("R6 per off cycles pin1", STAB + 2, n);
        irq_n = 2'b11;
        wait_cpu(n);
        check("R8 release delay pin1", 2, n);

        // R9 reset-pin wake
        write_pd(1'b1);
        repeat (5) tick();
        check("R2 osc off before reset", 0, int'(osc_en));
        rst_pin = 1'b1;
        #2;
        check("R9 osc on at once", 1, int'(osc_en));
        wait_per(n);
        check("R9 restart cycles", STAB + 2, n);
        check("R9 both clocks back", 2'b11, int'({cpu_clk_en, per_clk_en}));

        // R10 burst then reset request
        b = 0; c = 0;
        for (int k = 0; k < 100; k++) begin
            if (!ram_block) break;
            b++;
            c += cpu_clk_en;
            tick();
        end
        check("R10 burst length", BURST, b);
        check("R10 cpu on during burst", BURST, c);
        check("R10 reset request", 1, int'(core_rst_req));
        tick();
        check("R10 reset request one cycle", 0, int'(core_rst_req));
        rst_pin = 1'b0;
        repeat (3) tick();

        finish_run();
    end

endmodule